// File: doc/BRIEF.md
# Channel-Parallel 1D Convolution Array

This block is a square array of multiply-accumulate cells that holds its filter weights in place and streams 8-bit signed activations past them. In depthwise mode every array row belongs to one channel. The row keeps the last samples of its own activation stream in a shift chain that advances one cell per clock. It multiplies that window by the row's stationary taps and sums the products into a 24-bit signed result. Because every row owns a channel, all rows produce results at the same time. Feeding a row with a line of the feature map gives a horizontal 1xK pass, and feeding it with a column gives a vertical Kx1 pass.

In pointwise mode the same cells and taps form a weight-stationary matrix-vector product. Row r takes the dot product of its taps with the vector made of the first L activation inputs, which gives one output channel of a 1x1 convolution per row. The active length L is set at run time. Taps at positions L and above take no part in the sum. Settings and taps can only change while no activation is still inside the array, so a stream is never computed with mixed settings.

Top module: `chanconv_array`

## Requirements
- R1: After reset, every resValid bit is 0 and every resOut field is 0. The mode is depthwise, the active length L is 1 and every tap is 0.
- R2: In depthwise mode (cfgMode = 0), the result for row r registered at clock edge n is the signed sum over c < L of tap[r][c] times x_r(n-c). Here x_r(n) is actIn[8r+:8] sampled at edge n. The first result of an unbroken run therefore appears L-1 cycles after its first sample.
- R3: In depthwise mode, resValid[r] is high after edge n exactly when actValid[r] was high at each of the edges n-L+1 to n. While resValid[r] is low, resOut[24r+:24] is 0.
- R4: L may be any value from 1 to N, and both extremes behave as R2 and R3 state.
- R5: Taps at positions L and above have no effect on any result.
- R6: In pointwise mode (cfgMode = 1), row r registers at edge n the signed sum over c < L of tap[r][c] times actIn[8c+:8] sampled at that edge. The result is valid exactly when actValid[c] was high at that edge for every c < L.
- R7: In depthwise mode, a row's output depends only on that row's own activation stream, valid bits and taps.
- R8: A settings write (cfgWe) or a tap write (tapWe) takes effect only when actValid was all zero at each of the previous N-1 clock edges. Otherwise it is ignored. A sample taken at the same edge as an accepted write still uses the old settings and taps.
- R9: A settings write whose cfgLen is 0 or greater than N is ignored as a whole, so the mode does not change either.
- R10: A tap write loads row tapRow. Tap c of that row takes tapData[8c+:8], read as signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Settings write strobe |
| cfgMode | input | 1 | 0 selects depthwise, 1 selects pointwise |
| cfgLen | input | $clog2(N+1) | Active length L |
| tapWe | input | 1 | Tap write strobe |
| tapRow | input | $clog2(N) | Row addressed by the tap write |
| tapData | input | 8*N | Taps for that row, tap c in bits 8c+:8 |
| actIn | input | 8*N | Activations, input r in bits 8r+:8 |
| actValid | input | N | Valid bit for each activation input |
| resOut | output | 24*N | Results, row r in bits 24r+:24 |
| resValid | output | N | Valid bit for each result row |

## Verification
The case most likely to break is a settings or tap write that lands on the same clock edge as an activation sample. That sample has to be computed with the old values, and the write has to be judged only on the samples from earlier edges. The bench provokes this in two ways. In the first, the write comes with a fresh sample exactly N-1 idle cycles after a stream, so the write is accepted. In the second, the write comes after only N-2 idle cycles and must be ignored. A reference model that works on sample history predicts the results of the stream that follows. The effect of each write is judged only through those results at the ports.

// File: rtl/chanconv_pkg.sv
package chanconv_pkg;
  localparam int ACT_W = 8;
  localparam int ACC_W = 24;

  typedef struct packed {
    logic tapLoad;
    logic pwMode;
  } ctlStrobe_t;
endpackage

// File: rtl/chanconv_ctrl.sv
module chanconv_ctrl
  import chanconv_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic          cfgMode,
  input  logic [LW-1:0] cfgLen,
  input  logic          tapWe,
  input  logic          pipeBusy,
  output ctlStrobe_t    ctlStr,
  output logic [LW-1:0] curLen
);
  logic modeQ;
  logic lenOk;

  assign lenOk = (cfgLen != '0) && (cfgLen <= LW'(N));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      curLen <= LW'(1);
    end else if (cfgWe && !pipeBusy && lenOk) begin
      modeQ  <= cfgMode;
      curLen <= cfgLen;
    end
  end

  always_comb begin
    ctlStr.tapLoad = tapWe && !pipeBusy;
    ctlStr.pwMode  = modeQ;
  end
endmodule

// File: rtl/chanconv_dpath.sv
module chanconv_dpath
  import chanconv_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N + 1),
  parameter int RW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctlStr,
  input  logic [LW-1:0]      curLen,
  input  logic [RW-1:0]      tapRow,
  input  logic [N*ACT_W-1:0] tapData,
  input  logic [N*ACT_W-1:0] actIn,
  input  logic [N-1:0]       actValid,
  output logic [N*ACC_W-1:0] resOut,
  output logic [N-1:0]       resValid,
  output logic               pipeBusy
);
  logic signed [ACT_W-1:0] tapQ  [N][N];
  logic signed [ACT_W-1:0] inAct [N];
  logic [N-1:0]            rowBusy;

  for (genvar i = 0; i < N; i++) begin : g_in
    assign inAct[i] = actIn[i*ACT_W +: ACT_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          tapQ[r][c] <= '0;
    end else if (ctlStr.tapLoad && (int'(tapRow) < N)) begin
      for (int c = 0; c < N; c++)
        tapQ[tapRow][c] <= tapData[c*ACT_W +: ACT_W];
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    logic signed [ACT_W-1:0]   stAct [N-1];
    logic [N-2:0]              stVld;
    logic signed [ACT_W-1:0]   winA  [N];
    logic [N-1:0]              winV;
    logic signed [ACC_W-1:0]   sum;
    logic                      allV;
    logic signed [ACT_W-1:0]   opA;
    logic                      opV;
    logic signed [2*ACT_W-1:0] prod;
    logic signed [ACC_W-1:0]   resQ;
    logic                      vldQ;

    assign winA[0] = inAct[r];
    assign winV[0] = actValid[r];
    for (genvar c = 1; c < N; c++) begin : g_win
      assign winA[c] = stAct[c-1];
      assign winV[c] = stVld[c-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < N - 1; k++) begin
          stAct[k] <= '0;
          stVld[k] <= 1'b0;
        end
      end else begin
        stAct[0] <= inAct[r];
        stVld[0] <= actValid[r];
        for (int k = 1; k < N - 1; k++) begin
          stAct[k] <= stAct[k-1];
          stVld[k] <= stVld[k-1];
        end
      end
    end

    always_comb begin
      sum  = '0;
      allV = 1'b1;
      opA  = '0;
      opV  = 1'b0;
      prod = '0;
      for (int c = 0; c < N; c++) begin
        if (c < int'(curLen)) begin
          opA  = ctlStr.pwMode ? inAct[c]    : winA[c];
          opV  = ctlStr.pwMode ? actValid[c] : winV[c];
          prod = tapQ[r][c] * opA;
          sum  = sum + ACC_W'(prod);
          allV = allV & opV;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resQ <= '0;
        vldQ <= 1'b0;
      end else begin
        resQ <= allV ? sum : '0;
        vldQ <= allV;
      end
    end

    assign resOut[r*ACC_W +: ACC_W] = resQ;
    assign resValid[r]              = vldQ;
    assign rowBusy[r]               = |stVld;
  end

  assign pipeBusy = |rowBusy;
endmodule

// File: rtl/chanconv_array.sv
module chanconv_array
  import chanconv_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N + 1),
  parameter int RW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgMode,
  input  logic [LW-1:0]      cfgLen,
  input  logic               tapWe,
  input  logic [RW-1:0]      tapRow,
  input  logic [N*ACT_W-1:0] tapData,
  input  logic [N*ACT_W-1:0] actIn,
  input  logic [N-1:0]       actValid,
  output logic [N*ACC_W-1:0] resOut,
  output logic [N-1:0]       resValid
);
  ctlStrobe_t    ctlStr;
  logic [LW-1:0] curLen;
  logic          pipeBusy;

  chanconv_ctrl #(.N(N), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgLen(cfgLen), .tapWe(tapWe), .pipeBusy(pipeBusy),
    .ctlStr(ctlStr), .curLen(curLen)
  );

  chanconv_dpath #(.N(N), .LW(LW), .RW(RW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctlStr(ctlStr), .curLen(curLen),
    .tapRow(tapRow), .tapData(tapData), .actIn(actIn),
    .actValid(actValid), .resOut(resOut), .resValid(resValid),
    .pipeBusy(pipeBusy)
  );
endmodule

// File: rtl/chanconv_chk.sv
module chanconv_chk
  import chanconv_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic [N-1:0]       actValid,
  input logic [N*ACC_W-1:0] resOut,
  input logic [N-1:0]       resValid,
  input logic               curMode,
  input logic [LW-1:0]      curLen
);
  int idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idleCnt <= N;
    else if (|actValid)     idleCnt <= 0;
    else if (idleCnt < N)   idleCnt <= idleCnt + 1;
  end

  AST_CFG_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && idleCnt < N - 1) |=> ($stable(curMode) && $stable(curLen))); // R8

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (curLen != '0) && (curLen <= LW'(N))); // R9

  for (genvar r = 0; r < N; r++) begin : g_chk
    AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !resValid[r] |-> (resOut[r*ACC_W +: ACC_W] == '0)); // R3

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
      resValid[r] |-> ($past(curMode) ? $past(actValid[0]) : $past(actValid[r]))); // R3

    AST_UNIT_KERNEL: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(curMode) && $past(curLen) == LW'(1)) |-> (resValid[r] == $past(actValid[r]))); // R2
  end
endmodule

bind chanconv_array chanconv_chk #(.N(N), .LW(LW)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .actValid(actValid),
  .resOut(resOut), .resValid(resValid), .curMode(ctlStr.pwMode),
  .curLen(curLen)
);

// File: tb/chanconv_array_bench.sv
module chanconv_array_bench;
  localparam int N  = 8;
  localparam int LW = $clog2(N + 1);
  localparam int RW = $clog2(N);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cfgWe = 1'b0;
  logic            cfgMode = 1'b0;
  logic [LW-1:0]   cfgLen = '0;
  logic            tapWe = 1'b0;
  logic [RW-1:0]   tapRow = '0;
  logic [N*8-1:0]  tapData = '0;
  logic [N*8-1:0]  actIn = '0;
  logic [N-1:0]    actValid = '0;
  wire  [N*24-1:0] resOut;
  wire  [N-1:0]    resValid;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    cmpOn = 1'b0;
  bit    done = 1'b0;

  int mTap [N][N];
  int mMode, mLen;
  int hA [N][N];
  bit hV [N][N];
  int expO [N];
  bit expV [N];

  always #2 clk = ~clk;

  chanconv_array #(.N(N)) u_chanconv_array (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgLen(cfgLen), .tapWe(tapWe), .tapRow(tapRow), .tapData(tapData),
    .actIn(actIn), .actValid(actValid), .resOut(resOut), .resValid(resValid)
  );

  function automatic int sAct(int i);
    return int'($signed(actIn[i*8 +: 8]));
  endfunction

  always @(posedge clk) begin : model
    bit drained;
    int s;
    bit av;
    int a;
    bit v;
    if (!rstN) begin
      mMode = 0;
      mLen  = 1;
      for (int r = 0; r < N; r++) begin
        expO[r] = 0;
        expV[r] = 1'b0;
        for (int c = 0; c < N; c++) begin
          mTap[r][c] = 0;
          hA[r][c]   = 0;
          hV[r][c]   = 1'b0;
        end
      end
    end else begin
      drained = 1'b1;
      for (int r = 0; r < N; r++)
        for (int k = 0; k < N - 1; k++)
          if (hV[r][k]) drained = 1'b0;
      for (int r = 0; r < N; r++) begin
        s  = 0;
        av = 1'b1;
        for (int c = 0; c < mLen; c++) begin
          if (mMode == 1) begin
            a = sAct(c); v = actValid[c];
          end else if (c == 0) begin
            a = sAct(r); v = actValid[r];
          end else begin
            a = hA[r][c-1]; v = hV[r][c-1];
          end
          s  = s + mTap[r][c] * a;
          av = av & v;
        end
        expO[r] = av ? s : 0;
        expV[r] = av;
      end
      if (cfgWe && drained && int'(cfgLen) >= 1 && int'(cfgLen) <= N) begin
        mMode = int'(cfgMode);
        mLen  = int'(cfgLen);
      end
      if (tapWe && drained)
        for (int c = 0; c < N; c++)
          mTap[int'(tapRow)][c] = int'($signed(tapData[c*8 +: 8]));
      for (int r = 0; r < N; r++) begin
        for (int k = N - 1; k > 0; k--) begin
          hA[r][k] = hA[r][k-1];
          hV[r][k] = hV[r][k-1];
        end
        hA[r][0] = sAct(r);
        hV[r][0] = actValid[r];
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn && !done) begin
      for (int r = 0; r < N; r++) begin
        checks++;
        if (resValid[r] !== expV[r] ||
            int'($signed(resOut[r*24 +: 24])) != expO[r]) begin
          errors++;
          $display("FAIL %s row %0d: actual valid=%0b value=%0d, expected valid=%0b value=%0d",
                   tag, r, resValid[r], int'($signed(resOut[r*24 +: 24])), expV[r], expO[r]);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      actValid = '0;
      cfgWe    = 1'b0;
      tapWe    = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic setCfg(int m, int l);
    cfgWe   = 1'b1;
    cfgMode = 1'(m);
    cfgLen  = LW'(l);
    @(negedge clk);
    cfgWe   = 1'b0;
  endtask

  task automatic loadTaps(int seed);
    for (int r = 0; r < N; r++) begin
      tapWe  = 1'b1;
      tapRow = RW'(r);
      for (int c = 0; c < N; c++)
        tapData[c*8 +: 8] = 8'((r * 29 + c * 11 + seed * 53) % 256);
      @(negedge clk);
    end
    tapWe = 1'b0;
  endtask

  task automatic stream(int n, int pat);
    repeat (n) begin
      for (int r = 0; r < N; r++)
        actIn[r*8 +: 8] = 8'($urandom_range(0, 255));
      case (pat)
        0:       actValid = '1;
        1:       actValid = N'($urandom);
        default: actValid = ($urandom_range(0, 3) != 0) ? '1 : '0;
      endcase
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : seq
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    checks++;
    if (resValid !== '0 || resOut !== '0) begin
      errors++;
      $display("FAIL R1: actual valid=%0h out=%0h, expected 0 and 0", resValid, resOut);
    end
    rstN  = 1'b1;
    cmpOn = 1'b1;
    tag = "R1"; stream(6, 0);                     // zero taps, length 1
    tag = "R10"; idle(N); loadTaps(1); stream(4, 0);
    tag = "R2"; idle(N); setCfg(0, 3); stream(24, 0);
    tag = "R3"; stream(40, 2); stream(30, 1);
    tag = "R5"; idle(N); setCfg(0, 2); stream(20, 0);
    idle(N); loadTaps(2); stream(20, 0);
    tag = "R4"; idle(N); setCfg(0, N); stream(30, 0); stream(20, 2);
    idle(N); setCfg(0, 1); stream(15, 1);
    tag = "R7"; idle(N); setCfg(0, 4); stream(40, 1);
    // R8: writes during a stream are dropped
    tag = "R8"; stream(5, 0);
    actValid = '1; setCfg(0, 6);
    loadTaps(3);
    stream(15, 0);
    // R8: write with a sample after N-1 idle edges is taken
    idle(N - 1);
    actValid = '1; setCfg(0, 2);
    stream(10, 0);
    // R8: one idle edge short, write dropped
    idle(N - 2); setCfg(0, 7); stream(12, 0);
    tag = "R9"; idle(N); setCfg(1, 0); stream(10, 0);
    idle(N); setCfg(1, N + 1); stream(10, 0);
    tag = "R6"; idle(N); setCfg(1, N); stream(20, 0); stream(20, 1);
    idle(N); setCfg(1, 4); loadTaps(4); stream(20, 2);
    idle(N);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule